// File: doc/BRIEF.md
# Command/Response Buffer Register Window

This block is the register window a host uses to talk to a security co-processor through a single shared command/response buffer. It answers aligned reads and writes of 1, 2, 4 or 8 bytes into a 4 KiB offset space. That space holds locality ownership bits, a fixed interface identification word, a ready/idle handshake, a start doorbell, the command and response size and address registers, and a 3968-byte shared data buffer starting at offset 0x80.

The bus side is always ready. Every accepted request gets exactly one response in the following cycle, carrying read data and an error flag. Accepting a start request sends a one-cycle launch pulse to a downstream command sequencer. That sequencer reports completion on a done input, and the done input clears the start bit. Interrupts, cancellation and multiple localities are not modelled: the cancel and interrupt-enable offsets take writes silently.

Top module: `cmdbuf_regfile`

## Requirements
- R1: After reset, offset 0x00 reads 0x81 (established bit 0 and request-valid bit 7 set). Offset 0x44 bit 1 (idle) reads 1. Command size (0x58) and response size (0x64) read 0xF80. The command address (0x5C low, 0x60 high) and the response address (0x68, 64-bit) both read WINDOW_BASE + 0x80.
- R2: An access whose address is not a multiple of its size returns error = 1 and changes no state.
- R3: An access at or above offset 0x1000 returns an error. An aligned 8-byte access at 0xFF8 is legal.
- R4: A write to 0x08 with bit 1 set clears granted (0x0C bit 0) and assigned (0x00 bit 1), even when bit 0 is also set.
- R5: A write to 0x08 with bit 1 clear and bit 0 set sets both granted and assigned.
- R6: A write to 0x40 with bits [1:0] = 01 clears idle, and 10 sets idle. The values 00 and 11 leave idle unchanged.
- R7: A write to 0x4C with bit 0 = 1 while start (0x4C bit 0) is 0 sets start and raises `launch` for exactly one cycle, in the same cycle as the response. A write of 0, or a write while start is 1, has no effect.
- R8: `done` clears start. A later start write launches again.
- R9: Narrow write data is shifted left by 8 × (offset mod 4) before it is decoded against its 32-bit register.
- R10: Writes to 0x48 and 0x50, of any legal size, return no error and change no state.
- R11: Writes to any other offset below 0x58, and writes wider than 4 bytes to 0x08, 0x40 or 0x4C, return an error and change nothing.
- R12: Offset 0x30 reads a 64-bit ID: type [3:0], version [7:4], transfer-size capability [12:11] = 3, command-buffer capability bit 14 = 1, selector [18:17] = 1, revision [31:24], vendor [47:32], device [63:48].
- R13: The size/address registers (0x58–0x6F) and the data buffer take byte-lane writes. Reads return the addressed bytes right-justified.
- R14: Reserved offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Always 1: request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the window |
| req_size | input | 2 | log2 of access bytes (0..3) |
| req_wdata | input | 64 | Write data, right-justified |
| rsp_valid | output | 1 | Response, one cycle after accept |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 64 | Read data, right-justified |
| launch | output | 1 | One-cycle command launch pulse |
| done | input | 1 | Sequencer completion, clears start |

## Verification
The bench builds the block with non-default vendor, device and revision values. Because of that, reading the ID word checks each field's bit position: a swapped or misplaced field would not also match the default values. ADDR_W stays at 16, so addresses above the 4 KiB window can be issued and the out-of-window error is within reach. The window base stays at its default, so the reset address values are fixed numbers the vectors can state.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    localparam int WIN_BYTES  = 4096;
    localparam int BUF_OFFSET = 'h80;
    localparam int BUF_BYTES  = WIN_BYTES - BUF_OFFSET;
    localparam int BUF_WORDS  = BUF_BYTES / 8;
    localparam int BUF_IDX_W  = $clog2(BUF_WORDS);

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_LOC,
        TGT_READY,
        TGT_START,
        TGT_SINK,
        TGT_STORE,
        TGT_BAD
    } tgt_e;

    function automatic logic [63:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    size_mask = 64'h0000_0000_0000_00FF;
            2'd1:    size_mask = 64'h0000_0000_0000_FFFF;
            2'd2:    size_mask = 64'h0000_0000_FFFF_FFFF;
            default: size_mask = '1;
        endcase
    endfunction

    function automatic logic [7:0] lane_enable(input logic [1:0] sz, input logic [2:0] lo);
        logic [7:0] base;
        case (sz)
            2'd0:    base = 8'h01;
            2'd1:    base = 8'h03;
            2'd2:    base = 8'h0F;
            default: base = 8'hFF;
        endcase
        lane_enable = base << lo;
    endfunction

endpackage

// File: rtl/cmdbuf_decode.sv
module cmdbuf_decode
    import cmdbuf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              err,
    output tgt_e              tgt,
    output logic [11:0]       off
);

    logic [2:0]  align_mask;
    logic        misaligned;
    logic        outside;
    logic [11:0] word32;

    always_comb begin
        case (size)
            2'd0:    align_mask = 3'b000;
            2'd1:    align_mask = 3'b001;
            2'd2:    align_mask = 3'b011;
            default: align_mask = 3'b111;
        endcase
        misaligned = |(addr[2:0] & align_mask);
        outside    = |addr[ADDR_W-1:12];
        off        = addr[11:0];
        word32     = {addr[11:2], 2'b00};

        tgt = TGT_NONE;
        if (write) begin
            if (word32 >= 12'(BUF_OFFSET)) begin
                tgt = TGT_STORE;
            end else begin
                case (word32)
                    12'h008: tgt = (size == 2'd3) ? TGT_BAD : TGT_LOC;
                    12'h040: tgt = (size == 2'd3) ? TGT_BAD : TGT_READY;
                    12'h04C: tgt = (size == 2'd3) ? TGT_BAD : TGT_START;
                    12'h048, 12'h050: tgt = TGT_SINK;
                    12'h058, 12'h05C, 12'h060, 12'h064, 12'h068, 12'h06C: tgt = TGT_STORE;
                    default: tgt = TGT_BAD;
                endcase
            end
        end
        err = misaligned || outside || (tgt == TGT_BAD);
    end

endmodule

// File: rtl/cmdbuf_ctrl.sv
module cmdbuf_ctrl
    import cmdbuf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  tgt_e        tgt,
    input  logic [1:0]  lane,
    input  logic [1:0]  size,
    input  logic [31:0] wdata,
    input  logic        done,
    output logic        assigned,
    output logic        granted,
    output logic        idle,
    output logic        start,
    output logic        launch
);

    typedef struct packed {
        logic assigned;
        logic granted;
        logic idle;
        logic start;
        logic launch;
    } ctrl_t;

    ctrl_t       st_d, st_q;
    logic [31:0] val;

    always_comb begin
        val  = (wdata & size_mask(size)[31:0]) << {lane, 3'b000};
        st_d = st_q;
        st_d.launch = 1'b0;
        if (done) st_d.start = 1'b0;
        if (we) begin
            case (tgt)
                TGT_LOC: begin
                    if (val[1]) begin
                        st_d.granted  = 1'b0;
                        st_d.assigned = 1'b0;
                    end else if (val[0]) begin
                        st_d.granted  = 1'b1;
                        st_d.assigned = 1'b1;
                    end
                end
                TGT_READY: begin
                    if (val[1:0] == 2'b01)      st_d.idle = 1'b0;
                    else if (val[1:0] == 2'b10) st_d.idle = 1'b1;
                end
                TGT_START: begin
                    if (val[0] && !st_q.start) begin
                        st_d.start  = 1'b1;
                        st_d.launch = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{assigned: 1'b0, granted: 1'b0, idle: 1'b1, start: 1'b0, launch: 1'b0};
        else        st_q <= st_d;
    end

    assign assigned = st_q.assigned;
    assign granted  = st_q.granted;
    assign idle     = st_q.idle;
    assign start    = st_q.start;
    assign launch   = st_q.launch;

    // R4
    relinquish_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && tgt == TGT_LOC && val[1]) |=> (!granted && !assigned));

    // R6
    ready_pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && tgt == TGT_READY && val[1:0] == 2'b11) |=> $stable(idle));

    // R7
    launch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (start && $past(!start)));

    // R8
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && done) |=> !start);

endmodule

// File: rtl/cmdbuf_store.sv
module cmdbuf_store
    import cmdbuf_pkg::*;
#(
    parameter logic [63:0] WINDOW_BASE = 64'h0000_0000_FED4_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [11:0] off,
    input  logic [1:0]  size,
    input  logic [63:0] wdata,
    output logic [63:0] reg_word,
    output logic [63:0] buf_word
);

    localparam logic [31:0] SIZE_RST = 32'(BUF_BYTES);
    localparam logic [63:0] ADDR_RST = WINDOW_BASE + 64'(BUF_OFFSET);

    typedef struct packed {
        logic [63:0] w2;
        logic [63:0] w1;
        logic [63:0] w0;
    } regs_t;

    regs_t                regs_d, regs_q;
    logic [7:0]           be;
    logic [63:0]          lanes;
    logic [63:0]          bitmask;
    logic [8:0]           word_sel;
    logic [BUF_IDX_W-1:0] bidx;
    logic                 in_buf;
    logic [63:0]          mem_q [BUF_WORDS];

    always_comb begin
        be       = lane_enable(size, off[2:0]);
        lanes    = wdata << {off[2:0], 3'b000};
        word_sel = off[11:3];
        in_buf   = (off >= 12'(BUF_OFFSET));
        bidx     = BUF_IDX_W'(word_sel - 9'(BUF_OFFSET / 8));
        for (int b = 0; b < 8; b++) bitmask[8*b +: 8] = {8{be[b]}};

        regs_d = regs_q;
        if (we && !in_buf) begin
            case (word_sel)
                9'd11:   regs_d.w0 = (regs_q.w0 & ~bitmask) | (lanes & bitmask);
                9'd12:   regs_d.w1 = (regs_q.w1 & ~bitmask) | (lanes & bitmask);
                9'd13:   regs_d.w2 = (regs_q.w2 & ~bitmask) | (lanes & bitmask);
                default: ;
            endcase
        end

        case (word_sel)
            9'd11:   reg_word = regs_q.w0;
            9'd12:   reg_word = regs_q.w1;
            9'd13:   reg_word = regs_q.w2;
            default: reg_word = '0;
        endcase
        buf_word = in_buf ? mem_q[bidx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.w0 <= {ADDR_RST[31:0], SIZE_RST};
            regs_q.w1 <= {SIZE_RST, ADDR_RST[63:32]};
            regs_q.w2 <= ADDR_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we && in_buf) begin
            for (int b = 0; b < 8; b++) begin
                if (be[b]) mem_q[bidx][8*b +: 8] <= lanes[8*b +: 8];
            end
        end
    end

endmodule

// File: rtl/cmdbuf_regfile.sv
module cmdbuf_regfile
    import cmdbuf_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter logic [63:0] WINDOW_BASE = 64'h0000_0000_FED4_0000,
    parameter logic [3:0]  IF_TYPE     = 4'h1,
    parameter logic [3:0]  IF_VER      = 4'h1,
    parameter logic [7:0]  IF_REV      = 8'h00,
    parameter logic [15:0] IF_VENDOR   = 16'h1014,
    parameter logic [15:0] IF_DEVICE   = 16'h1014
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    output logic              launch,
    input  logic              done
);

    localparam logic [63:0] ID_WORD = {IF_DEVICE, IF_VENDOR, IF_REV, 5'd0, 2'd1, 2'd0,
                                       1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, IF_VER, IF_TYPE};

    typedef struct packed {
        logic        valid;
        logic        err;
        logic [63:0] rdata;
    } rsp_t;

    rsp_t        rsp_d, rsp_q;
    logic        fire;
    logic        dec_err;
    tgt_e        dec_tgt;
    logic [11:0] off;
    logic        wr_ok;
    logic        assigned, granted, idle, start;
    logic [63:0] reg_word, buf_word, word;

    assign req_ready = 1'b1;
    assign fire      = req_valid && req_ready;

    cmdbuf_decode #(.ADDR_W(ADDR_W)) u_decode (
        .write (req_write),
        .addr  (req_addr),
        .size  (req_size),
        .err   (dec_err),
        .tgt   (dec_tgt),
        .off   (off)
    );

    assign wr_ok = fire && req_write && !dec_err;

    cmdbuf_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_ok),
        .tgt      (dec_tgt),
        .lane     (off[1:0]),
        .size     (req_size),
        .wdata    (req_wdata[31:0]),
        .done     (done),
        .assigned (assigned),
        .granted  (granted),
        .idle     (idle),
        .start    (start),
        .launch   (launch)
    );

    cmdbuf_store #(.WINDOW_BASE(WINDOW_BASE)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_ok && dec_tgt == TGT_STORE),
        .off      (off),
        .size     (req_size),
        .wdata    (req_wdata),
        .reg_word (reg_word),
        .buf_word (buf_word)
    );

    always_comb begin
        if (off >= 12'(BUF_OFFSET)) begin
            word = buf_word;
        end else begin
            case (off[11:3])
                9'd0:    word = {32'h0, 24'h0, 1'b1, 5'b0, assigned, 1'b1};
                9'd1:    word = {30'h0, 1'b0, granted, 32'h0};
                9'd6:    word = ID_WORD;
                9'd8:    word = {30'h0, idle, 1'b0, 32'h0};
                9'd9:    word = {31'h0, start, 32'h0};
                9'd11, 9'd12, 9'd13: word = reg_word;
                default: word = '0;
            endcase
        end

        rsp_d.valid = fire;
        rsp_d.err   = fire && dec_err;
        rsp_d.rdata = '0;
        if (fire && !req_write && !dec_err)
            rsp_d.rdata = (word >> {off[2:0], 3'b000}) & size_mask(req_size);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

    // R2
    bad_access_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> ($stable(idle) && $stable(granted) && $stable(assigned) && !launch));

    // R3
    outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (|req_addr[ADDR_W-1:12])) |=> (rsp_valid && rsp_err));

    // R7
    launch_has_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (rsp_valid && !rsp_err));

endmodule

// File: tb/cmdbuf_regfile_test.sv
module cmdbuf_regfile_test;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [1:0]  sz;
        logic [63:0] wd;
        logic        err;
        logic [63:0] rd;
        logic        ln;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 61;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0000, 2'd2, 64'h0, 1'b0, 64'h81, 1'b0, 8'd1},                    // R1
        '{1'b0, 16'h0044, 2'd2, 64'h0, 1'b0, 64'h2, 1'b0, 8'd1},                     // R1
        '{1'b0, 16'h0058, 2'd3, 64'h0, 1'b0, 64'hFED40080_00000F80, 1'b0, 8'd1},     // R1
        '{1'b0, 16'h0060, 2'd3, 64'h0, 1'b0, 64'h00000F80_00000000, 1'b0, 8'd1},     // R1
        '{1'b0, 16'h0068, 2'd3, 64'h0, 1'b0, 64'h00000000_FED40080, 1'b0, 8'd1},     // R1
        '{1'b0, 16'h0030, 2'd3, 64'h0, 1'b0, 64'h5E1DA5C3_3C025811, 1'b0, 8'd12},    // R12
        '{1'b0, 16'h0034, 2'd2, 64'h0, 1'b0, 64'h5E1DA5C3, 1'b0, 8'd12},             // R12
        '{1'b0, 16'h0031, 2'd0, 64'h0, 1'b0, 64'h58, 1'b0, 8'd12},                   // R12
        '{1'b1, 16'h0003, 2'd2, 64'h1, 1'b1, 64'h0, 1'b0, 8'd2},                     // R2
        '{1'b0, 16'h1000, 2'd3, 64'h0, 1'b1, 64'h0, 1'b0, 8'd3},                     // R3
        '{1'b1, 16'h1000, 2'd0, 64'h1, 1'b1, 64'h0, 1'b0, 8'd3},                     // R3
        '{1'b1, 16'h0FF8, 2'd3, 64'hCAFEF00D_12345678, 1'b0, 64'h0, 1'b0, 8'd3},     // R3
        '{1'b0, 16'h0FF8, 2'd3, 64'h0, 1'b0, 64'hCAFEF00D_12345678, 1'b0, 8'd3},     // R3
        '{1'b1, 16'h0008, 2'd2, 64'h1, 1'b0, 64'h0, 1'b0, 8'd5},                     // R5
        '{1'b0, 16'h000C, 2'd2, 64'h0, 1'b0, 64'h1, 1'b0, 8'd5},                     // R5
        '{1'b0, 16'h0000, 2'd2, 64'h0, 1'b0, 64'h83, 1'b0, 8'd5},                    // R5
        '{1'b1, 16'h0008, 2'd2, 64'h3, 1'b0, 64'h0, 1'b0, 8'd4},                     // R4
        '{1'b0, 16'h000C, 2'd2, 64'h0, 1'b0, 64'h0, 1'b0, 8'd4},                     // R4
        '{1'b0, 16'h0000, 2'd2, 64'h0, 1'b0, 64'h81, 1'b0, 8'd4},                    // R4
        '{1'b1, 16'h0040, 2'd2, 64'h1, 1'b0, 64'h0, 1'b0, 8'd6},                     // R6
        '{1'b0, 16'h0044, 2'd2, 64'h0, 1'b0, 64'h0, 1'b0, 8'd6},                     // R6
        '{1'b1, 16'h0040, 2'd2, 64'h3, 1'b0, 64'h0, 1'b0, 8'd6},                     // R6
        '{1'b0, 16'h0044, 2'd2, 64'h0, 1'b0, 64'h0, 1'b0, 8'd6},                     // R6
        '{1'b1, 16'h0040, 2'd2, 64'h2, 1'b0, 64'h0, 1'b0, 8'd6},                     // R6
        '{1'b0, 16'h0044, 2'd2, 64'h0, 1'b0, 64'h2, 1'b0, 8'd6},                     // R6
        '{1'b1, 16'h0040, 2'd2, 64'h0, 1'b0, 64'h0, 1'b0, 8'd6},                     // R6
        '{1'b0, 16'h0044, 2'd2, 64'h0, 1'b0, 64'h2, 1'b0, 8'd6},                     // R6
        '{1'b1, 16'h0040, 2'd2, 64'h1, 1'b0, 64'h0, 1'b0, 8'd6},                     // R6
        '{1'b0, 16'h0044, 2'd2, 64'h0, 1'b0, 64'h0, 1'b0, 8'd6},                     // R6
        '{1'b1, 16'h0041, 2'd0, 64'h2, 1'b0, 64'h0, 1'b0, 8'd9},                     // R9
        '{1'b0, 16'h0044, 2'd2, 64'h0, 1'b0, 64'h0, 1'b0, 8'd9},                     // R9
        '{1'b1, 16'h0040, 2'd0, 64'h2, 1'b0, 64'h0, 1'b0, 8'd9},                     // R9
        '{1'b0, 16'h0044, 2'd2, 64'h0, 1'b0, 64'h2, 1'b0, 8'd9},                     // R9
        '{1'b1, 16'h000A, 2'd1, 64'h1, 1'b0, 64'h0, 1'b0, 8'd9},                     // R9
        '{1'b0, 16'h000C, 2'd2, 64'h0, 1'b0, 64'h0, 1'b0, 8'd9},                     // R9
        '{1'b1, 16'h004C, 2'd2, 64'h1, 1'b0, 64'h0, 1'b1, 8'd7},                     // R7
        '{1'b0, 16'h004C, 2'd2, 64'h0, 1'b0, 64'h1, 1'b0, 8'd7},                     // R7
        '{1'b1, 16'h004C, 2'd2, 64'h1, 1'b0, 64'h0, 1'b0, 8'd7},                     // R7
        '{1'b1, 16'h0048, 2'd2, 64'hFFFFFFFF, 1'b0, 64'h0, 1'b0, 8'd10},             // R10
        '{1'b1, 16'h0050, 2'd3, 64'hFFFFFFFF_FFFFFFFF, 1'b0, 64'h0, 1'b0, 8'd10},    // R10
        '{1'b0, 16'h004C, 2'd2, 64'h0, 1'b0, 64'h1, 1'b0, 8'd10},                    // R10
        '{1'b0, 16'h0044, 2'd2, 64'h0, 1'b0, 64'h2, 1'b0, 8'd10},                    // R10
        '{1'b1, 16'h0000, 2'd2, 64'hFF, 1'b1, 64'h0, 1'b0, 8'd11},                   // R11
        '{1'b0, 16'h0000, 2'd2, 64'h0, 1'b0, 64'h81, 1'b0, 8'd11},                   // R11
        '{1'b1, 16'h0030, 2'd3, 64'h0, 1'b1, 64'h0, 1'b0, 8'd11},                    // R11
        '{1'b1, 16'h0008, 2'd3, 64'h1, 1'b1, 64'h0, 1'b0, 8'd11},                    // R11
        '{1'b0, 16'h000C, 2'd2, 64'h0, 1'b0, 64'h0, 1'b0, 8'd11},                    // R11
        '{1'b1, 16'h0044, 2'd2, 64'h0, 1'b1, 64'h0, 1'b0, 8'd11},                    // R11
        '{1'b0, 16'h0044, 2'd2, 64'h0, 1'b0, 64'h2, 1'b0, 8'd11},                    // R11
        '{1'b1, 16'h005C, 2'd2, 64'hDEADBEEF, 1'b0, 64'h0, 1'b0, 8'd13},             // R13
        '{1'b0, 16'h0058, 2'd3, 64'h0, 1'b0, 64'hDEADBEEF_00000F80, 1'b0, 8'd13},    // R13
        '{1'b1, 16'h0080, 2'd3, 64'h11223344_55667788, 1'b0, 64'h0, 1'b0, 8'd13},    // R13
        '{1'b0, 16'h0083, 2'd0, 64'h0, 1'b0, 64'h55, 1'b0, 8'd13},                   // R13
        '{1'b0, 16'h0084, 2'd2, 64'h0, 1'b0, 64'h11223344, 1'b0, 8'd13},             // R13
        '{1'b1, 16'h0085, 2'd0, 64'hAB, 1'b0, 64'h0, 1'b0, 8'd13},                   // R13
        '{1'b0, 16'h0080, 2'd3, 64'h0, 1'b0, 64'h1122AB44_55667788, 1'b0, 8'd13},    // R13
        '{1'b0, 16'h0020, 2'd3, 64'h0, 1'b0, 64'h0, 1'b0, 8'd14},                    // R14
        '{1'b0, 16'h0074, 2'd2, 64'h0, 1'b0, 64'h0, 1'b0, 8'd14},                    // R14
        '{1'b0, 16'h0038, 2'd3, 64'h0, 1'b0, 64'h0, 1'b0, 8'd14},                    // R14
        '{1'b1, 16'h0042, 2'd2, 64'h2, 1'b1, 64'h0, 1'b0, 8'd2},                     // R2
        '{1'b0, 16'h0044, 2'd2, 64'h0, 1'b0, 64'h2, 1'b0, 8'd2}                      // R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, launch;
    logic [63:0] rsp_rdata;
    logic        done = 1'b0;

    int checks = 0;
    int fails  = 0;
    logic finished = 1'b0;

    logic        got_err, got_ln, got_valid;
    logic [63:0] got_rd;

    always #10 clk = ~clk;

    cmdbuf_regfile #(
        .ADDR_W    (16),
        .IF_REV    (8'h3C),
        .IF_VENDOR (16'hA5C3),
        .IF_DEVICE (16'h5E1D)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .launch    (launch),
        .done      (done)
    );

    task automatic check(input int req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [15:0] addr, input logic [1:0] sz, input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_size  = sz;
        req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        got_valid = rsp_valid;
        got_err   = rsp_err;
        got_rd    = rsp_rdata;
        got_ln    = launch;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1, "rsp_valid in reset", 64'(rsp_valid), 64'h0);
        check(7, "launch in reset", 64'(launch), 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].sz, VECS[i].wd);
            check(int'(VECS[i].req), $sformatf("vec %0d valid", i), 64'(got_valid), 64'h1);
            check(int'(VECS[i].req), $sformatf("vec %0d err", i), 64'(got_err), 64'(VECS[i].err));
            check(int'(VECS[i].req), $sformatf("vec %0d launch", i), 64'(got_ln), 64'(VECS[i].ln));
            if (!VECS[i].wr && !VECS[i].err)
                check(int'(VECS[i].req), $sformatf("vec %0d rdata", i), got_rd, VECS[i].rd);
        end

        // response lasts one cycle
        @(negedge clk);
        check(7, "rsp_valid drops", 64'(rsp_valid), 64'h0);

        // R8: done clears start, then a zero write does nothing, then a new launch
        @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        access(1'b0, 16'h004C, 2'd2, 64'h0);
        check(8, "start after done", got_rd, 64'h0);
        access(1'b1, 16'h004C, 2'd2, 64'h0);
        check(7, "zero start write launch", 64'(got_ln), 64'h0);
        access(1'b0, 16'h004C, 2'd2, 64'h0);
        check(7, "start after zero write", got_rd, 64'h0);
        access(1'b1, 16'h004C, 2'd0, 64'h1);
        check(8, "relaunch", 64'(got_ln), 64'h1);
        @(negedge clk);
        check(7, "launch one cycle", 64'(launch), 64'h0);

        // R2: unaligned start write does not launch
        @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        access(1'b1, 16'h004E, 2'd2, 64'h1);
        check(2, "unaligned start err", 64'(got_err), 64'h1);
        check(2, "unaligned start launch", 64'(got_ln), 64'h0);

        // R1: reset again restores idle and addresses
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        access(1'b0, 16'h0058, 2'd3, 64'h0);
        check(1, "cmd regs after reset", got_rd, 64'hFED40080_00000F80);
        access(1'b0, 16'h004C, 2'd2, 64'h0);
        check(1, "start after reset", got_rd, 64'h0);

        finish_run();
    end

endmodule